// File: doc/BRIEF.md
# Row Cache Bank State Tracker

This block keeps the per-bank bookkeeping for a DRAM whose banks each carry a row cache beside the array. It records two things for every bank. The first is whether the array row is open, and which row. The second is which row, if any, sits in the cache. From that state the block judges each decoded command as it arrives. It reports whether the command is legal, whether a read is served from the cache, and whether an access first needs a row activated. It also runs the per-bank precharge timer that an explicit precharge or an auto-precharge starts.

The cache and the array row are tracked apart. A read of the cached row is allowed after the array row has closed, and also while it is still precharging. A write always needs the array row open, and it keeps the cache coherent. A mode input picks the write-transfer policy. When it is set, activates and writes to a new row load that row into the cache. When it is clear, they leave the cache alone. A legal command updates the state on the clock edge that registers it. An illegal command changes no state, and one cycle later it raises an error pulse.

Top module: `row_cache_tracker`

## Requirements
- R1: While `rst` is high and after it falls, every bank shows array closed, cache invalid, precharge idle, and `cmd_err_o` low.
- R2: Command codes on `cmd_i` are 0 idle, 1 activate, 2 read, 3 write, 4 precharge; codes 5 to 7 act as idle. Idle is always legal. An activate is legal only when the addressed bank's array is closed and its precharge timer is idle, and it opens the array at `row_i`.
- R3: A legal activate loads `row_i` into the bank's cache when `wr_xfer_i` is 1, and leaves the cache unchanged when it is 0. Bank b's cached row is `cache_row_o[b*ROW_W +: ROW_W]`.
- R4: A read whose row equals the bank's valid cached row is legal and raises `cache_hit_o`, even when the array is closed or precharging.
- R5: A read that misses the cache is legal only when the array is open at `row_i`; it then loads that row into the cache. Any other miss is illegal and raises `need_act_o`.
- R6: A write is legal only when the array is open at `row_i`, even when `row_i` matches the cached row; otherwise it is illegal and raises `need_act_o`.
- R7: A legal write to a row other than the cached one loads that row into the cache when `wr_xfer_i` is 1 and leaves the cache unchanged when it is 0; a write to the cached row keeps it valid.
- R8: A legal read or write with `ap_i` high on an open bank shows that bank closed and precharging from the next cycle on; with `ap_i` low the bank stays open.
- R9: A precharge on an open bank closes it and holds `pre_busy_o` high for exactly TRP cycles; an activate to a bank that is busy is illegal, and busy and open are never both set.
- R10: An illegal command changes no bank state and raises `cmd_err_o` for exactly the one following cycle; a legal command leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | $clog2(NUM_BANKS) | Addressed bank |
| row_i | input | ROW_W | Row the command refers to |
| ap_i | input | 1 | Auto-precharge request on a read or write |
| wr_xfer_i | input | 1 | 1 = write-transfer policy, 0 = no-write-transfer |
| arr_open_o | output | NUM_BANKS | Array row open, per bank |
| cache_valid_o | output | NUM_BANKS | Cache holds a row, per bank |
| cache_row_o | output | NUM_BANKS*ROW_W | Cached row, per bank |
| pre_busy_o | output | NUM_BANKS | Precharge timer running, per bank |
| cmd_legal_o | output | 1 | Current command is legal (combinational) |
| cache_hit_o | output | 1 | Current read is served by the cache |
| need_act_o | output | 1 | Current access needs a row activated first |
| cmd_err_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
Several rules are checked on every cycle. A bank is never open and busy at once. An activate to a busy bank, or a write to a closed bank, is flagged illegal. A read of the valid cached row is always a legal hit. The error pulse follows exactly the illegal commands. A legal auto-precharge access leaves its bank busy. Some behaviour only the bench's scenarios can show. These are the two cache policies under `wr_xfer_i`, the reload of the cache by a read miss, and the exact length of the precharge window. Another is that an illegal command leaves the open row untouched, which the bench shows through later commands.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    localparam int CMD_W = 3;

    // Read or write: the commands that carry an auto-precharge flag
    function automatic logic is_access(input logic [CMD_W-1:0] c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/rc_cmd_check.sv
module rc_cmd_check
    import rc_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [ROW_W-1:0] row,
    input  logic             open,
    input  logic [ROW_W-1:0] open_row,
    input  logic             cvalid,
    input  logic [ROW_W-1:0] crow,
    input  logic             busy,
    output logic             legal,
    output logic             hit,
    output logic             need_act
);

    logic open_match;
    logic cache_match;

    assign open_match  = open && (open_row == row);
    assign cache_match = cvalid && (crow == row);

    always_comb begin
        legal    = 1'b1;
        hit      = 1'b0;
        need_act = 1'b0;
        case (cmd)
            CMD_ACT: legal = !open && !busy;
            CMD_READ: begin
                legal    = cache_match || open_match;
                hit      = cache_match;
                need_act = !(cache_match || open_match);
            end
            CMD_WRITE: begin
                legal    = open_match;
                need_act = !open_match;
            end
            default: legal = 1'b1;
        endcase
    end

endmodule

// File: rtl/rc_bank.sv
module rc_bank
    import rc_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int TRP   = 3,
    localparam int CNT_W = $clog2(TRP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [CMD_W-1:0] cmd,
    input  logic [ROW_W-1:0] row,
    input  logic             ap,
    input  logic             wr_xfer,
    output logic             open_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             cvalid_o,
    output logic [ROW_W-1:0] crow_o,
    output logic             busy_o
);

    logic             open_q;
    logic [ROW_W-1:0] open_row_q;
    logic             cvalid_q;
    logic [ROW_W-1:0] crow_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cache_match;

    assign cache_match = cvalid_q && (crow_q == row);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
            cvalid_q   <= 1'b0;
            crow_q     <= '0;
            cnt_q      <= '0;
        end else begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (sel) begin
                case (cmd)
                    CMD_ACT: begin
                        open_q     <= 1'b1;
                        open_row_q <= row;
                        if (wr_xfer) begin
                            cvalid_q <= 1'b1;
                            crow_q   <= row;
                        end
                    end
                    CMD_READ: begin
                        if (!cache_match) begin
                            cvalid_q <= 1'b1;
                            crow_q   <= row;
                        end
                        if (ap && open_q) begin
                            open_q <= 1'b0;
                            cnt_q  <= CNT_W'(TRP);
                        end
                    end
                    CMD_WRITE: begin
                        if (wr_xfer && !cache_match) begin
                            cvalid_q <= 1'b1;
                            crow_q   <= row;
                        end
                        if (ap) begin
                            open_q <= 1'b0;
                            cnt_q  <= CNT_W'(TRP);
                        end
                    end
                    CMD_PRE: begin
                        if (open_q) begin
                            open_q <= 1'b0;
                            cnt_q  <= CNT_W'(TRP);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign open_o     = open_q;
    assign open_row_o = open_row_q;
    assign cvalid_o   = cvalid_q;
    assign crow_o     = crow_q;
    assign busy_o     = (cnt_q != '0);

endmodule

// File: rtl/row_cache_tracker.sv
module row_cache_tracker
    import rc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TRP       = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CMD_W-1:0]           cmd_i,
    input  logic [BANK_W-1:0]          bank_i,
    input  logic [ROW_W-1:0]           row_i,
    input  logic                       ap_i,
    input  logic                       wr_xfer_i,
    output logic [NUM_BANKS-1:0]       arr_open_o,
    output logic [NUM_BANKS-1:0]       cache_valid_o,
    output logic [NUM_BANKS*ROW_W-1:0] cache_row_o,
    output logic [NUM_BANKS-1:0]       pre_busy_o,
    output logic                       cmd_legal_o,
    output logic                       cache_hit_o,
    output logic                       need_act_o,
    output logic                       cmd_err_o
);

    logic [NUM_BANKS-1:0] open_v;
    logic [NUM_BANKS-1:0] cvalid_v;
    logic [NUM_BANKS-1:0] busy_v;
    logic [NUM_BANKS-1:0] sel_v;
    logic [ROW_W-1:0]     open_row_a [NUM_BANKS];
    logic [ROW_W-1:0]     crow_a     [NUM_BANKS];
    logic                 legal;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel_v[b] = legal && (bank_i == BANK_W'(b));

        rc_bank #(
            .ROW_W (ROW_W),
            .TRP   (TRP)
        ) i_bank (
            .clk        (clk),
            .rst        (rst),
            .sel        (sel_v[b]),
            .cmd        (cmd_i),
            .row        (row_i),
            .ap         (ap_i),
            .wr_xfer    (wr_xfer_i),
            .open_o     (open_v[b]),
            .open_row_o (open_row_a[b]),
            .cvalid_o   (cvalid_v[b]),
            .crow_o     (crow_a[b]),
            .busy_o     (busy_v[b])
        );

        assign cache_row_o[b*ROW_W +: ROW_W] = crow_a[b];
    end

    rc_cmd_check #(
        .ROW_W (ROW_W)
    ) i_check (
        .cmd      (cmd_i),
        .row      (row_i),
        .open     (open_v[bank_i]),
        .open_row (open_row_a[bank_i]),
        .cvalid   (cvalid_v[bank_i]),
        .crow     (crow_a[bank_i]),
        .busy     (busy_v[bank_i]),
        .legal    (legal),
        .hit      (cache_hit_o),
        .need_act (need_act_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err_o <= 1'b0;
        end else begin
            cmd_err_o <= !legal;
        end
    end

    assign arr_open_o    = open_v;
    assign cache_valid_o = cvalid_v;
    assign pre_busy_o    = busy_v;
    assign cmd_legal_o   = legal;

endmodule

// File: rtl/rc_tracker_chk.sv
module rc_tracker_chk
    import rc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [CMD_W-1:0]           cmd_i,
    input logic [BANK_W-1:0]          bank_i,
    input logic [ROW_W-1:0]           row_i,
    input logic                       ap_i,
    input logic [NUM_BANKS-1:0]       arr_open_o,
    input logic [NUM_BANKS-1:0]       cache_valid_o,
    input logic [NUM_BANKS*ROW_W-1:0] cache_row_o,
    input logic [NUM_BANKS-1:0]       pre_busy_o,
    input logic                       cmd_legal_o,
    input logic                       cache_hit_o,
    input logic                       cmd_err_o
);

    // R9
    busy_open_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_busy_o & arr_open_o) == '0);

    // R9
    act_busy_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_ACT && pre_busy_o[bank_i]) |-> !cmd_legal_o);

    // R6
    wr_closed_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_WRITE && !arr_open_o[bank_i]) |-> (!cmd_legal_o && !cache_hit_o));

    // R4
    rd_cache_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_READ && cache_valid_o[bank_i]
         && cache_row_o[bank_i*ROW_W +: ROW_W] == row_i) |-> (cmd_legal_o && cache_hit_o));

    // R10
    err_after_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_legal_o |=> cmd_err_o);

    // R10
    no_err_after_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_legal_o |=> !cmd_err_o);

    // R8
    ap_starts_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (is_access(cmd_i) && ap_i && cmd_legal_o && arr_open_o[bank_i])
        |=> (pre_busy_o[$past(bank_i)] && !arr_open_o[$past(bank_i)]));

endmodule

bind row_cache_tracker rc_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
) i_rc_tracker_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_i         (cmd_i),
    .bank_i        (bank_i),
    .row_i         (row_i),
    .ap_i          (ap_i),
    .arr_open_o    (arr_open_o),
    .cache_valid_o (cache_valid_o),
    .cache_row_o   (cache_row_o),
    .pre_busy_o    (pre_busy_o),
    .cmd_legal_o   (cmd_legal_o),
    .cache_hit_o   (cache_hit_o),
    .cmd_err_o     (cmd_err_o)
);

// File: tb/test_row_cache_tracker.sv
module test_row_cache_tracker;

    localparam int NB    = 4;
    localparam int RW    = 12;
    localparam int TRP   = 3;
    localparam int NVEC  = 22;
    localparam int VEC_W = 22;

    // {cmd[3], bank[2], row[12], ap, xfer, exp_legal, exp_hit, exp_need}
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {3'd1, 2'd0, 12'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 act b0
        {3'd2, 2'd0, 12'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 hit
        {3'd3, 2'd0, 12'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 write open row
        {3'd3, 2'd0, 12'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 wrong row
        {3'd1, 2'd0, 12'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 act on open
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 closed, empty
        {3'd1, 2'd1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 act no xfer
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 miss from array
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 now cached
        {3'd4, 2'd1, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 precharge
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 hit while busy
        {3'd3, 2'd1, 12'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 closed write
        {3'd1, 2'd1, 12'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 act while busy
        {3'd0, 2'd0, 12'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 idle
        {3'd1, 2'd1, 12'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 act after tRP
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 cache kept r1
        {3'd3, 2'd1, 12'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 no xfer
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 cache still r1
        {3'd3, 2'd1, 12'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 xfer loads r2
        {3'd2, 2'd1, 12'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 r1 gone
        {3'd2, 2'd1, 12'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 read with ap
        {3'd2, 2'd1, 12'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}  // R4 hit after close
    };

    logic                clk = 1'b0;
    logic                rst;
    logic [2:0]          cmd_i;
    logic [1:0]          bank_i;
    logic [RW-1:0]       row_i;
    logic                ap_i;
    logic                wr_xfer_i;
    logic [NB-1:0]       arr_open_o;
    logic [NB-1:0]       cache_valid_o;
    logic [NB*RW-1:0]    cache_row_o;
    logic [NB-1:0]       pre_busy_o;
    logic                cmd_legal_o;
    logic                cache_hit_o;
    logic                need_act_o;
    logic                cmd_err_o;

    int n_checks = 0;
    int n_errors = 0;
    logic s_legal, s_hit, s_need;

    always #5 clk = ~clk;

    row_cache_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .TRP(TRP)) i_row_cache_tracker (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i),
        .ap_i(ap_i), .wr_xfer_i(wr_xfer_i), .arr_open_o(arr_open_o),
        .cache_valid_o(cache_valid_o), .cache_row_o(cache_row_o),
        .pre_busy_o(pre_busy_o), .cmd_legal_o(cmd_legal_o),
        .cache_hit_o(cache_hit_o), .need_act_o(need_act_o), .cmd_err_o(cmd_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample combinational outputs before the
    // rising edge, return 1 ns after the edge with registered state settled.
    task automatic issue(input logic [2:0] c, input logic [1:0] b,
                         input logic [RW-1:0] r, input logic ap, input logic x);
        @(negedge clk);
        cmd_i = c; bank_i = b; row_i = r; ap_i = ap; wr_xfer_i = x;
        #2;
        s_legal = cmd_legal_o;
        s_hit   = cache_hit_o;
        s_need  = need_act_o;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_i = 3'd0; bank_i = '0; row_i = '0; ap_i = 1'b0; wr_xfer_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R1 open"},  int'(arr_open_o), 0);
        check({tag, " R1 valid"}, int'(cache_valid_o), 0);
        check({tag, " R1 busy"},  int'(pre_busy_o), 0);
        check({tag, " R1 err"},   int'(cmd_err_o), 0);
    endtask

    initial begin
        #50000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        do_reset();
        check_reset_state("first");

        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            issue(v[21:19], v[18:17], v[16:5], v[4], v[3]);
            check($sformatf("vec %0d R2-R9 legal", i), int'(s_legal), int'(v[2]));
            check($sformatf("vec %0d R4 hit", i),       int'(s_hit),   int'(v[1]));
            check($sformatf("vec %0d R5/R6 need", i),   int'(s_need),  int'(v[0]));
            check($sformatf("vec %0d R10 err", i),      int'(cmd_err_o), int'(!v[2]));
        end
        // After read with ap on bank 1: closed, busy; bank 0 still open
        check("R8 bank1 closed", int'(arr_open_o[1]), 0);
        check("R8 bank1 busy",   int'(pre_busy_o[1]), 1);
        check("R7 bank1 cached row", int'(cache_row_o[1*RW +: RW]), 2);
        check("R8 bank0 stays open", int'(arr_open_o[0]), 1);

        // Mid-run reset
        rst = 1'b1;
        do_reset();
        check_reset_state("second");

        // R3: activate without transfer leaves cache empty
        issue(3'd1, 2'd2, 12'd9, 1'b0, 1'b0);
        check("R3 act no xfer cache", int'(cache_valid_o[2]), 0);
        check("R2 act opens", int'(arr_open_o[2]), 1);
        // R10: illegal act with another row changes nothing
        issue(3'd1, 2'd2, 12'd11, 1'b0, 1'b1);
        check("R10 err pulse", int'(cmd_err_o), 1);
        check("R10 cache untouched", int'(cache_valid_o[2]), 0);
        issue(3'd0, 2'd0, 12'd0, 1'b0, 1'b0);
        check("R10 err one cycle", int'(cmd_err_o), 0);
        // Open row still 9: write with ap, transfer mode
        issue(3'd3, 2'd2, 12'd9, 1'b1, 1'b1);
        check("R10 open row kept", int'(s_legal), 1);
        check("R7 write xfer loads", int'(cache_valid_o[2]), 1);
        check("R7 write xfer row", int'(cache_row_o[2*RW +: RW]), 9);
        check("R8 write ap closes", int'(arr_open_o[2]), 0);
        begin
            int busy_cycles = 0;
            for (int k = 0; k < 8; k++) begin
                if (pre_busy_o[2]) busy_cycles++;
                issue(3'd0, 2'd0, 12'd0, 1'b0, 1'b0);
            end
            check("R9 busy length", busy_cycles, TRP);
        end
        // R8: ap low keeps bank open
        issue(3'd1, 2'd3, 12'd4, 1'b0, 1'b1);
        issue(3'd2, 2'd3, 12'd4, 1'b0, 1'b0);
        check("R8 no ap stays open", int'(arr_open_o[3]), 1);
        check("R8 no ap not busy", int'(pre_busy_o[3]), 0);
        // R9: precharge to closed bank 0 has no effect
        issue(3'd4, 2'd0, 12'd0, 1'b0, 1'b0);
        check("R9 pre closed bank idle", int'(pre_busy_o[0]), 0);
        // R2: reserved code behaves as idle
        issue(3'd6, 2'd3, 12'd4, 1'b0, 1'b0);
        check("R2 reserved legal", int'(s_legal), 1);
        check("R2 reserved no change", int'(arr_open_o[3]), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule